// File: doc/BRIEF.md
# I2C Slave Controller with Event Status Codes

This block is the target side of an I2C bus, run by software through four byte-wide registers. It samples the SCL and SDA lines, finds START, repeated START and STOP conditions, and compares each address byte with a programmed 7-bit address. When the address matches it acknowledges and enters either the receiver role or the transmitter role, chosen by the direction bit.

Each bus event leaves an 8-bit code in a status register and raises an event flag. For address and data-byte events the block holds SCL low until software has read the code, prepared or collected data, and cleared the flag. Software can clear the acknowledge enable to end a transfer. A receiver then answers NACK to the next byte. A transmitter sends its current byte as the last one and then leaves the bus alone for the rest of the transfer.

The bus pins are modelled as open-drain. The block only ever asserts a pull-low request on each line, and the input ports return the resolved line level.

Top module: `i2c_status_slave`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0xF8, and neither bus line is pulled low.
- R2: Register map (2-bit offset):
  - Offset 0 is control. Bit 0 is enable, bit 1 is acknowledge enable and bit 7 is the event flag; writing 1 to bit 7 clears the flag.
  - Offset 1 is status. It is read-only and returns 0xF8 whenever the flag is clear.
  - Offset 2 holds the own address in bits [7:1] and the general-call enable in bit 0.
  - Offset 3 is data.
- R3: With enable and acknowledge enable set, an address byte that matches the own address is acknowledged in the ninth clock and raises the flag. The status is 0x60 when the direction bit is 0 (write) and 0xA8 when it is 1 (read).
- R4: After an address event or a data-byte event that keeps the slave addressed (0x60, 0x70, 0x80, 0x90, 0xA8, 0xB8), SCL is held low while the flag is set. Writing 1 to the flag releases SCL. The events 0x88, 0x98, 0xA0, 0xC0 and 0xC8 raise the flag without holding SCL.
- R5: In the receiver role every received byte is stored in the data register. If acknowledge enable is set in the ninth clock, the byte is acknowledged and the status is 0x80. Otherwise the byte gets a NACK, the status is 0x88, and the slave stops being addressed.
- R6: The address byte 0x00 is acknowledged with status 0x70 only when general-call enable is set. Data bytes after it report 0x90 (ACK) or 0x98 (NACK). With general-call enable clear, the byte 0x00 gets a NACK and raises no flag.
- R7: In the transmitter role the data-register byte is loaded when the flag is cleared and sent MSB first. SDA changes only while SCL is low. A master ACK gives status 0xB8.
- R8: If acknowledge enable is clear when the flag is cleared before a transmitted byte, that byte is the last. A master ACK then gives 0xC8 and a master NACK gives 0xC0. In both cases the slave stops being addressed and leaves SDA released, so any further byte reads as 0xFF.
- R9: While acknowledge enable is clear, the own address gets a NACK and raises no flag. Address recognition returns at the next address once acknowledge enable is set again.
- R10: A STOP or repeated START while addressed raises the flag with status 0xA0. A repeated START begins a new address phase.
- R11: An address byte that matches neither the own address nor an enabled general call gets a NACK and leaves the flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hostWr | input | 1 | Register write strobe |
| hostAddr | input | 2 | Register offset for read and write |
| hostWdata | input | 8 | Register write data |
| hostRdata | output | 8 | Register read data, combinational from hostAddr |
| sclIn | input | 1 | Resolved SCL line level |
| sdaIn | input | 1 | Resolved SDA line level |
| sclDriveLow | output | 1 | Request to pull SCL low (clock stretch) |
| sdaDriveLow | output | 1 | Request to pull SDA low (ACK or data 0) |

## Verification
Each line passes through two synchronizer flops and one edge register, so the engine reacts three clock cycles after a line changes. The flag, the status code and the SCL hold appear one cycle after that. The bench master holds every SCL phase for 20 cycles and reads registers only in the low phase that follows a ninth clock, so each status or stretch result is already stable when it is sampled. Register reads are combinational. A register write takes effect at the next edge, and the bench waits a few cycles before checking that SCL has been released.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  localparam int BYTE_W    = 8;
  localparam int BIT_CNT_W = $clog2(BYTE_W + 1);
  localparam int REG_ADDR_W = 2;

  localparam logic [REG_ADDR_W-1:0] REG_CTRL   = 2'd0;
  localparam logic [REG_ADDR_W-1:0] REG_STATUS = 2'd1;
  localparam logic [REG_ADDR_W-1:0] REG_OWN    = 2'd2;
  localparam logic [REG_ADDR_W-1:0] REG_DATA   = 2'd3;

  localparam logic [BYTE_W-1:0] CODE_NONE      = 8'hF8;
  localparam logic [BYTE_W-1:0] CODE_RX_ADDR   = 8'h60;
  localparam logic [BYTE_W-1:0] CODE_RX_GCALL  = 8'h70;
  localparam logic [BYTE_W-1:0] CODE_RX_ACK    = 8'h80;
  localparam logic [BYTE_W-1:0] CODE_RX_NACK   = 8'h88;
  localparam logic [BYTE_W-1:0] CODE_GC_ACK    = 8'h90;
  localparam logic [BYTE_W-1:0] CODE_GC_NACK   = 8'h98;
  localparam logic [BYTE_W-1:0] CODE_END       = 8'hA0;
  localparam logic [BYTE_W-1:0] CODE_TX_ADDR   = 8'hA8;
  localparam logic [BYTE_W-1:0] CODE_TX_ACK    = 8'hB8;
  localparam logic [BYTE_W-1:0] CODE_TX_NACK   = 8'hC0;
  localparam logic [BYTE_W-1:0] CODE_TX_LAST   = 8'hC8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_WAIT
  } engState_t;

  typedef struct packed {
    logic              shiftIn;
    logic              loadTx;
    logic              shiftTx;
    logic              captureRx;
    logic              setFlag;
    logic [BYTE_W-1:0] code;
  } dpCmd_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen
);
  localparam int LINES = 2;

  logic [LINES-1:0] lineIn;
  logic [LINES-1:0] lineSync;
  logic [LINES-1:0] linePrev;

  assign lineIn = {sdaIn, sclIn};

  for (genvar g = 0; g < LINES; g++) begin : gLine
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe        <= '1;
        linePrev[g] <= 1'b1;
      end else begin
        pipe        <= {pipe[STAGES-2:0], lineIn[g]};
        linePrev[g] <= pipe[STAGES-1];
      end
    end
    assign lineSync[g] = pipe[STAGES-1];
  end

  assign sclS      = lineSync[0];
  assign sdaS      = lineSync[1];
  assign sclRise   = lineSync[0] & ~linePrev[0];
  assign sclFall   = ~lineSync[0] & linePrev[0];
  assign startSeen = lineSync[0] & linePrev[0] & linePrev[1] & ~lineSync[1];
  assign stopSeen  = lineSync[0] & linePrev[0] & ~linePrev[1] & lineSync[1];
endmodule

// File: rtl/i2c_slv_dp.sv
module i2c_slv_dp
  import i2c_slv_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hostWr,
  input  logic [REG_ADDR_W-1:0] hostAddr,
  input  logic [BYTE_W-1:0]     hostWdata,
  output logic [BYTE_W-1:0]     hostRdata,
  input  dpCmd_t                cmd,
  input  logic                  sdaS,
  output logic                  enable,
  output logic                  ackEn,
  output logic                  flag,
  output logic [BYTE_W-2:0]     ownAddr,
  output logic                  gcEn,
  output logic [BYTE_W-1:0]     rxByte,
  output logic                  txMsb
);
  logic [BYTE_W-1:0] codeReg, ownReg, dataReg, rxShift, txShift;
  logic              wrCtrl;

  assign wrCtrl = hostWr && (hostAddr == REG_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable  <= 1'b0;
      ackEn   <= 1'b0;
      flag    <= 1'b0;
      codeReg <= CODE_NONE;
      ownReg  <= '0;
    end else begin
      if (wrCtrl) begin
        enable <= hostWdata[0];
        ackEn  <= hostWdata[1];
      end
      if (cmd.setFlag) begin
        flag    <= 1'b1;
        codeReg <= cmd.code;
      end else if (wrCtrl && hostWdata[BYTE_W-1]) begin
        flag <= 1'b0;
      end
      if (hostWr && hostAddr == REG_OWN) ownReg <= hostWdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataReg <= '0;
      rxShift <= '0;
      txShift <= '1;
    end else begin
      if (cmd.shiftIn) rxShift <= {rxShift[BYTE_W-2:0], sdaS};
      if (cmd.captureRx) dataReg <= rxShift;
      else if (hostWr && hostAddr == REG_DATA) dataReg <= hostWdata;
      if (cmd.loadTx) txShift <= dataReg;
      else if (cmd.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b1};
    end
  end

  assign ownAddr = ownReg[BYTE_W-1:1];
  assign gcEn    = ownReg[0];
  assign rxByte  = rxShift;
  assign txMsb   = txShift[BYTE_W-1];

  always_comb begin
    case (hostAddr)
      REG_CTRL:   hostRdata = {flag, {(BYTE_W-3){1'b0}}, ackEn, enable};
      REG_STATUS: hostRdata = flag ? codeReg : CODE_NONE;
      REG_OWN:    hostRdata = ownReg;
      default:    hostRdata = dataReg;
    endcase
  end

  // R2: a write of 1 to the flag clears it unless an event lands in the same cycle
  p_flag_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wrCtrl && hostWdata[BYTE_W-1] && !cmd.setFlag) |=> !flag);

  // R4: an event always wins over a simultaneous clear
  p_event_raises_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.setFlag |=> flag);
endmodule

// File: rtl/i2c_slv_ctrl.sv
module i2c_slv_ctrl
  import i2c_slv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              ackEn,
  input  logic              flag,
  input  logic [BYTE_W-2:0] ownAddr,
  input  logic              gcEn,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txMsb,
  input  logic              sclS,
  input  logic              sdaS,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startSeen,
  input  logic              stopSeen,
  output dpCmd_t            cmd,
  output logic              sclLow,
  output logic              sdaLow
);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT  = BIT_CNT_W'(BYTE_W - 1);
  localparam logic [BIT_CNT_W-1:0] FULL_BYTE = BIT_CNT_W'(BYTE_W);

  engState_t            state, stateN;
  logic [BIT_CNT_W-1:0] bitCnt, cntN;
  logic isTx, isTxN, isGc, isGcN, addressed, addrN;
  logic lastByte, lastN, ackDrive, ackDrvN, masterAck, mAckN;
  logic ownHit, gcHit;

  assign ownHit = (rxByte[BYTE_W-1:1] == ownAddr);
  assign gcHit  = gcEn && (rxByte == '0);

  always_comb begin
    cmd     = '0;
    stateN  = state;
    cntN    = bitCnt;
    isTxN   = isTx;
    isGcN   = isGc;
    addrN   = addressed;
    lastN   = lastByte;
    ackDrvN = ackDrive;
    mAckN   = masterAck;
    if (!enable) begin
      stateN  = ST_IDLE;
      addrN   = 1'b0;
      ackDrvN = 1'b0;
    end else if (startSeen || stopSeen) begin
      stateN  = startSeen ? ST_ADDR : ST_IDLE;
      cntN    = '0;
      ackDrvN = 1'b0;
      addrN   = 1'b0;
      if (addressed) begin
        cmd.setFlag = 1'b1;
        cmd.code    = CODE_END;
      end
    end else begin
      unique case (state)
        ST_ADDR, ST_RX: begin
          if (sclRise && bitCnt != FULL_BYTE) begin
            cmd.shiftIn = 1'b1;
            cntN        = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == FULL_BYTE) begin
            if (state == ST_ADDR) begin
              if (ackEn && ownHit) begin
                isTxN   = rxByte[0];
                isGcN   = 1'b0;
                ackDrvN = 1'b1;
                stateN  = ST_ADDR_ACK;
              end else if (ackEn && gcHit) begin
                isTxN   = 1'b0;
                isGcN   = 1'b1;
                ackDrvN = 1'b1;
                stateN  = ST_ADDR_ACK;
              end else begin
                stateN = ST_IDLE;
              end
            end else begin
              cmd.captureRx = 1'b1;
              ackDrvN       = ackEn;
              stateN        = ST_RX_ACK;
            end
          end
        end
        ST_ADDR_ACK: if (sclFall) begin
          ackDrvN     = 1'b0;
          addrN       = 1'b1;
          cmd.setFlag = 1'b1;
          cmd.code    = isTx ? CODE_TX_ADDR : (isGc ? CODE_RX_GCALL : CODE_RX_ADDR);
          stateN      = ST_WAIT;
        end
        ST_RX_ACK: if (sclFall) begin
          ackDrvN     = 1'b0;
          cmd.setFlag = 1'b1;
          if (ackDrive) begin
            cmd.code = isGc ? CODE_GC_ACK : CODE_RX_ACK;
            stateN   = ST_WAIT;
          end else begin
            cmd.code = isGc ? CODE_GC_NACK : CODE_RX_NACK;
            stateN   = ST_IDLE;
            addrN    = 1'b0;
          end
        end
        ST_WAIT: if (!flag) begin
          cntN = '0;
          if (isTx) begin
            cmd.loadTx = 1'b1;
            lastN      = !ackEn;
            stateN     = ST_TX;
          end else begin
            stateN = ST_RX;
          end
        end
        ST_TX: if (sclFall) begin
          if (bitCnt == LAST_BIT) begin
            stateN = ST_TX_ACK;
          end else begin
            cntN        = bitCnt + 1'b1;
            cmd.shiftTx = 1'b1;
          end
        end
        ST_TX_ACK: begin
          if (sclRise) mAckN = !sdaS;
          if (sclFall) begin
            cmd.setFlag = 1'b1;
            if (!masterAck) begin
              cmd.code = CODE_TX_NACK;
              stateN   = ST_IDLE;
              addrN    = 1'b0;
            end else if (lastByte) begin
              cmd.code = CODE_TX_LAST;
              stateN   = ST_IDLE;
              addrN    = 1'b0;
            end else begin
              cmd.code = CODE_TX_ACK;
              stateN   = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      isTx      <= 1'b0;
      isGc      <= 1'b0;
      addressed <= 1'b0;
      lastByte  <= 1'b0;
      ackDrive  <= 1'b0;
      masterAck <= 1'b0;
    end else begin
      state     <= stateN;
      bitCnt    <= cntN;
      isTx      <= isTxN;
      isGc      <= isGcN;
      addressed <= addrN;
      lastByte  <= lastN;
      ackDrive  <= ackDrvN;
      masterAck <= mAckN;
    end
  end

  assign sclLow = flag && (state == ST_WAIT);
  assign sdaLow = ((state == ST_TX) && !txMsb) ||
                  (((state == ST_ADDR_ACK) || (state == ST_RX_ACK)) && ackDrive);

  // R7: the slave never moves SDA while the synchronized SCL is high
  p_sda_moves_scl_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !$stable(sdaLow)) |-> !sclS);

  // R4: clock stretching only happens with the flag pending
  p_stretch_needs_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sclLow |-> flag);

  // R4: once the flag is cleared while waiting, SCL is let go
  p_clear_releases_scl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && state == ST_WAIT && !flag && !startSeen && !stopSeen) |=> !sclLow);

  // R9: an address byte with acknowledge disabled is never acknowledged
  p_no_ack_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !startSeen && !stopSeen && state == ST_ADDR && sclFall &&
     bitCnt == FULL_BYTE && !ackEn) |=> !sdaLow);

  // R8: after the last byte the slave neither stretches nor drives SDA
  p_last_byte_detach_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !startSeen && !stopSeen && state == ST_TX_ACK && sclFall && lastByte)
      |=> (!sclLow && !sdaLow));
endmodule

// File: rtl/i2c_status_slave.sv
module i2c_status_slave
  import i2c_slv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hostWr,
  input  logic [1:0] hostAddr,
  input  logic [7:0] hostWdata,
  output logic [7:0] hostRdata,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sclDriveLow,
  output logic       sdaDriveLow
);
  dpCmd_t            cmd;
  logic              sclS, sdaS, sclRise, sclFall, startSeen, stopSeen;
  logic              enable, ackEn, flag, gcEn, txMsb;
  logic [BYTE_W-2:0] ownAddr;
  logic [BYTE_W-1:0] rxByte;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rst_n(rst_n), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen)
  );

  i2c_slv_dp uDp (
    .clk(clk), .rst_n(rst_n), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .cmd(cmd), .sdaS(sdaS),
    .enable(enable), .ackEn(ackEn), .flag(flag), .ownAddr(ownAddr),
    .gcEn(gcEn), .rxByte(rxByte), .txMsb(txMsb)
  );

  i2c_slv_ctrl uCtrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ackEn(ackEn), .flag(flag),
    .ownAddr(ownAddr), .gcEn(gcEn), .rxByte(rxByte), .txMsb(txMsb),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen), .cmd(cmd),
    .sclLow(sclDriveLow), .sdaLow(sdaDriveLow)
  );
endmodule

// File: tb/tb_i2c_status_slave.sv
module tb_i2c_status_slave;
  localparam int HALF = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hostWr = 1'b0;
  logic [1:0] hostAddr = 2'd0;
  logic [7:0] hostWdata = 8'h00;
  logic [7:0] hostRdata;
  logic       sclM = 1'b1, sdaM = 1'b1;
  logic       sclBus, sdaBus, sclDriveLow, sdaDriveLow;

  assign sclBus = sclM & ~sclDriveLow;
  assign sdaBus = sdaM & ~sdaDriveLow;

  always #5 clk = ~clk;

  i2c_status_slave dut (
    .clk(clk), .rst_n(rst_n), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .sclIn(sclBus), .sdaIn(sdaBus),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow)
  );

  typedef struct {
    string      req;
    logic [7:0] val;
  } expItem_t;

  expItem_t   expQ[$];
  logic [7:0] obsQ[$];
  int         compared = 0;
  int         mismatched = 0;
  bit         finished = 0;

  // monitor: pairs each observed value with the expectation pushed before it
  always @(negedge clk) begin
    while (expQ.size() > 0 && obsQ.size() > 0) begin
      expItem_t e;
      logic [7:0] o;
      e = expQ.pop_front();
      o = obsQ.pop_front();
      compared++;
      if (o !== e.val) begin
        mismatched++;
        $display("FAIL %s: actual 0x%02h expected 0x%02h", e.req, o, e.val);
      end
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectVal(input string req, input logic [7:0] val);
    expItem_t e;
    e.req = req;
    e.val = val;
    expQ.push_back(e);
  endtask

  task automatic chk(input string req, input logic [7:0] expv, input logic [7:0] act);
    expectVal(req, expv);
    obsQ.push_back(act);
  endtask

  task automatic hostWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostWdata = d; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    hostAddr = a;
    #1 d = hostRdata;
  endtask

  task automatic chkReg(input string req, input logic [1:0] a, input logic [7:0] expv);
    logic [7:0] d;
    hostRead(a, d);
    chk(req, expv, d);
  endtask

  task automatic bitXfer(input logic b, output logic r);
    sdaM = b;
    waitCyc(5);
    sclM = 1'b1;
    while (!sclBus) @(negedge clk);
    waitCyc(HALF);
    r = sdaBus;
    sclM = 1'b0;
    waitCyc(HALF);
  endtask

  task automatic busStart();
    sdaM = 1'b1;
    waitCyc(5);
    sclM = 1'b1;
    while (!sclBus) @(negedge clk);
    waitCyc(HALF);
    sdaM = 1'b0;
    waitCyc(HALF);
    sclM = 1'b0;
    waitCyc(HALF);
  endtask

  task automatic busStop();
    sdaM = 1'b0;
    waitCyc(5);
    sclM = 1'b1;
    while (!sclBus) @(negedge clk);
    waitCyc(HALF);
    sdaM = 1'b1;
    waitCyc(HALF);
  endtask

  task automatic writeByte(input logic [7:0] b, output logic acked);
    logic r;
    for (int i = 7; i >= 0; i--) bitXfer(b[i], r);
    bitXfer(1'b1, r);
    acked = !r;
  endtask

  task automatic readByte(output logic [7:0] d, input logic giveAck);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bitXfer(1'b1, r);
      d[i] = r;
    end
    bitXfer(!giveAck, r);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    logic       ack;
    logic [7:0] d;
    waitCyc(4);
    rst_n = 1'b1;
    waitCyc(2);

    // R1 reset state
    chkReg("R1 ctrl", 2'd0, 8'h00);
    chkReg("R1 status", 2'd1, 8'hF8);
    chk("R1 scl drive", 8'h00, {7'd0, sclDriveLow});
    chk("R1 sda drive", 8'h00, {7'd0, sdaDriveLow});

    hostWrite(2'd2, 8'hB4);             // own address 0x5A, general call off
    hostWrite(2'd0, 8'h03);
    chkReg("R2 own address readback", 2'd2, 8'hB4);

    // receiver: address + write, then data bytes
    busStart();
    writeByte(8'hB4, ack);
    chk("R3 address ack", 8'h01, {7'd0, ack});
    chkReg("R2 flag set in ctrl", 2'd0, 8'h83);
    chkReg("R3 status write address", 2'd1, 8'h60);
    chk("R4 scl held while flag", 8'h01, {7'd0, sclDriveLow});
    hostWrite(2'd0, 8'h83);
    waitCyc(3);
    chk("R4 scl released on clear", 8'h00, {7'd0, sclDriveLow});
    chkReg("R2 status idle when clear", 2'd1, 8'hF8);
    writeByte(8'h3C, ack);
    chk("R5 data ack", 8'h01, {7'd0, ack});
    chkReg("R5 status data ack", 2'd1, 8'h80);
    chkReg("R5 data stored", 2'd3, 8'h3C);
    hostWrite(2'd0, 8'h81);             // acknowledge off, clear flag
    writeByte(8'h55, ack);
    chk("R5 data nack", 8'h00, {7'd0, ack});
    chkReg("R5 status data nack", 2'd1, 8'h88);
    chkReg("R5 nack byte stored", 2'd3, 8'h55);
    chk("R4 no stretch after nack", 8'h00, {7'd0, sclDriveLow});
    hostWrite(2'd0, 8'h83);
    busStop();
    chkReg("R5 detached, stop raises nothing", 2'd0, 8'h03);

    // R10 stop while addressed
    busStart();
    writeByte(8'hB4, ack);
    hostWrite(2'd0, 8'h83);
    writeByte(8'h11, ack);
    chkReg("R5 second data ack", 2'd1, 8'h80);
    hostWrite(2'd0, 8'h83);
    busStop();
    chkReg("R10 stop while addressed", 2'd1, 8'hA0);
    chk("R4 no stretch on stop", 8'h00, {7'd0, sclDriveLow});
    hostWrite(2'd0, 8'h83);

    // transmitter with last byte acknowledged by the master
    busStart();
    writeByte(8'hB5, ack);
    chk("R3 read address ack", 8'h01, {7'd0, ack});
    chkReg("R3 status read address", 2'd1, 8'hA8);
    hostWrite(2'd3, 8'hC3);
    hostWrite(2'd0, 8'h83);
    readByte(d, 1'b1);
    chk("R7 byte sent msb first", 8'hC3, d);
    chkReg("R7 status data ack", 2'd1, 8'hB8);
    chk("R4 scl held after tx ack", 8'h01, {7'd0, sclDriveLow});
    hostWrite(2'd3, 8'h96);
    hostWrite(2'd0, 8'h81);             // last byte
    readByte(d, 1'b1);
    chk("R8 last byte value", 8'h96, d);
    chkReg("R8 status last acked", 2'd1, 8'hC8);
    chk("R8 no stretch after last", 8'h00, {7'd0, sclDriveLow});
    hostWrite(2'd0, 8'h81);
    readByte(d, 1'b0);
    chk("R8 detached reads ones", 8'hFF, d);
    busStop();
    chkReg("R8 no event after detach", 2'd0, 8'h01);
    hostWrite(2'd0, 8'h03);

    // transmitter ended by master NACK
    busStart();
    writeByte(8'hB5, ack);
    hostWrite(2'd3, 8'h12);
    hostWrite(2'd0, 8'h83);
    readByte(d, 1'b0);
    chk("R7 byte before nack", 8'h12, d);
    chkReg("R8 status master nack", 2'd1, 8'hC0);
    hostWrite(2'd0, 8'h83);
    busStop();
    chkReg("R8 nack detach quiet", 2'd0, 8'h03);

    // R11 foreign address
    busStart();
    writeByte(8'h66, ack);
    chk("R11 foreign address nack", 8'h00, {7'd0, ack});
    chkReg("R11 flag stays clear", 2'd0, 8'h03);
    busStop();

    // R9 acknowledge disabled, then resumed
    hostWrite(2'd0, 8'h01);
    busStart();
    writeByte(8'hB4, ack);
    chk("R9 own address ignored", 8'h00, {7'd0, ack});
    chkReg("R9 no flag", 2'd0, 8'h01);
    busStop();
    hostWrite(2'd0, 8'h03);
    busStart();
    writeByte(8'hB4, ack);
    chk("R9 recognition resumes", 8'h01, {7'd0, ack});
    chkReg("R9 status after resume", 2'd1, 8'h60);
    hostWrite(2'd0, 8'h83);

    // R10 repeated start while addressed, then read
    busStart();
    chkReg("R10 repeated start event", 2'd1, 8'hA0);
    chk("R4 no stretch on repeated start", 8'h00, {7'd0, sclDriveLow});
    hostWrite(2'd0, 8'h83);
    writeByte(8'hB5, ack);
    chk("R10 new address phase ack", 8'h01, {7'd0, ack});
    chkReg("R10 status read after restart", 2'd1, 8'hA8);
    hostWrite(2'd3, 8'h5E);
    hostWrite(2'd0, 8'h83);
    readByte(d, 1'b0);
    chk("R7 byte after restart", 8'h5E, d);
    hostWrite(2'd0, 8'h83);
    busStop();

    // R6 general call
    hostWrite(2'd2, 8'hB5);
    busStart();
    writeByte(8'h00, ack);
    chk("R6 general call ack", 8'h01, {7'd0, ack});
    chkReg("R6 status general call", 2'd1, 8'h70);
    hostWrite(2'd0, 8'h83);
    writeByte(8'h44, ack);
    chkReg("R6 status gc data ack", 2'd1, 8'h90);
    chkReg("R6 gc data stored", 2'd3, 8'h44);
    hostWrite(2'd0, 8'h81);
    writeByte(8'h45, ack);
    chk("R6 gc data nack", 8'h00, {7'd0, ack});
    chkReg("R6 status gc data nack", 2'd1, 8'h98);
    hostWrite(2'd0, 8'h83);
    busStop();
    hostWrite(2'd2, 8'hB4);
    busStart();
    writeByte(8'h00, ack);
    chk("R6 general call disabled nack", 8'h00, {7'd0, ack});
    chkReg("R6 no flag when disabled", 2'd0, 8'h03);
    busStop();

    waitCyc(5);
    if (expQ.size() != 0 || obsQ.size() != 0) begin
      mismatched++;
      $display("FAIL scoreboard: actual %0d left expected 0", expQ.size() + obsQ.size());
    end
    finish();
  end
endmodule